// File: doc/BRIEF.md
# Feedback-Driven Fetch Throttle

This block throttles instruction fetch to keep a die region near a target temperature. Each time a new temperature sample is presented with a strobe, a signed fixed-point PID controller works out how far the reading is above the target. It then updates its integral and derivative history and produces a saturated control value. That value is quantised into one of six fetch settings: always open, four of five cycles, two of three, one of two, one of three and one of five.

A periodic pattern generator turns the chosen setting into a per-cycle fetch-enable. It adopts a new setting only when its current pattern has finished, so every pattern it emits is whole. The gains, the target and the integrator clamp are plain inputs, held steady by the surrounding logic. The control value and the chosen setting are brought out next to the enable.

Top module: `fetch_pid_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, fetch_en is 1, duty_level is 0 and ctrl_out is 0. The error history and the integrator start from 0.
- R2: The controller state, ctrl_out and duty_level change only on a cycle where sample_stb is high. Temperature changes without a strobe have no effect.
- R3: With error e = temp_meas - temp_set, integrator I and step d = e - (previous sampled e), the control value is m = (Kp*(e + (Ki*I>>>4) + (Kd*d>>>4)))>>>4. The gains are unsigned with 4 fraction bits (16 = 1.0), and >>> is an arithmetic shift that rounds toward minus infinity.
- R4: m saturates to the signed 16-bit range [-32768, 32767] before it is output on ctrl_out.
- R5: On each strobe the integrator adds e and is clamped to [-int_limit, +int_limit]. The new integrator value is the one used in that strobe's m.
- R6: duty_level codes are 0 = always open, 1 = 4/5, 2 = 2/3, 3 = 1/2, 4 = 1/3 and 5 = 1/5. For m <= 0 the code is 0. Otherwise it is min(5, (m>>>4)+1).
- R7: Code 0 is forced whenever e <= 0 and the updated integrator is <= 0, whatever m is.
- R8: The patterns are made of slots. Code 1 opens slots 0-3 of 5, code 2 slots 0-1 of 3, code 3 slot 0 of 2, code 4 slot 0 of 3 and code 5 slot 0 of 5. Over any 30 consecutive cycles the enable counts are 30, 24, 20, 15, 10 and 6.
- R9: The generator takes duty_level only in the last slot of its current pattern and then begins at slot 0. A setting registered on a strobe edge is first seen at the following edge. A strobe taken in a pattern's last cycle therefore leaves one more full pattern at the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_meas | input | 12 | Sampled temperature, unsigned |
| temp_set | input | 12 | Target temperature, unsigned |
| sample_stb | input | 1 | Take one controller step this cycle |
| gain_p | input | 8 | Overall gain Kp, 4 fraction bits |
| gain_i | input | 8 | Integral gain Ki, 4 fraction bits |
| gain_d | input | 8 | Derivative gain Kd, 4 fraction bits |
| int_limit | input | 15 | Integrator clamp magnitude |
| fetch_en | output | 1 | Fetch allowed this cycle |
| duty_level | output | 3 | Setting chosen by the controller (R6 codes) |
| ctrl_out | output | 16 | Saturated control value m, signed |

## Verification
Two events can fall in the same cycle: a controller strobe that registers a new setting, and the generator reaching the last slot of its pattern. The bench first resets the block so that the pattern phase is known. It then sets up a change from the one-in-five pattern to the four-in-five pattern, with the strobe landing exactly on the last slot. Ten consecutive enable values are recorded and compared with the full bit sequence predicted by R9: one more whole one-in-five pattern, then the four-in-five pattern starting at slot 0.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    localparam int CTRL_W = 16;

    typedef enum logic [2:0] {
        DUTY_FULL = 3'd0,
        DUTY_4_5  = 3'd1,
        DUTY_2_3  = 3'd2,
        DUTY_1_2  = 3'd3,
        DUTY_1_3  = 3'd4,
        DUTY_1_5  = 3'd5
    } duty_t;

    typedef struct packed {
        logic [CTRL_W-1:0] m;
        duty_t             level;
    } pid_out_t;

    // number of slots in one pattern
    function automatic logic [2:0] duty_period(duty_t d);
        case (d)
            DUTY_4_5: return 3'd5;
            DUTY_2_3: return 3'd3;
            DUTY_1_2: return 3'd2;
            DUTY_1_3: return 3'd3;
            DUTY_1_5: return 3'd5;
            default:  return 3'd1;
        endcase
    endfunction

    // leading slots of a pattern that let fetch through
    function automatic logic [2:0] duty_open_slots(duty_t d);
        case (d)
            DUTY_4_5: return 3'd4;
            DUTY_2_3: return 3'd2;
            default:  return 3'd1;
        endcase
    endfunction

    function automatic duty_t duty_quant(logic signed [CTRL_W-1:0] m, int sh, logic force_open);
        logic signed [CTRL_W-1:0] q;
        q = m >>> sh;
        if (force_open || m <= 0)
            return DUTY_FULL;
        else if (q >= 4)
            return DUTY_1_5;
        else
            return duty_t'(3'(q) + 3'd1);
    endfunction

endpackage

// File: rtl/fpg_pid.sv
module fpg_pid
    import fpg_pkg::*;
#(
    parameter int TW      = 12,
    parameter int GW      = 8,
    parameter int GF      = 4,
    parameter int IW      = 16,
    parameter int STEP_SH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [TW-1:0] temp_meas,
    input  logic [TW-1:0] temp_set,
    input  logic [GW-1:0] gain_p,
    input  logic [GW-1:0] gain_i,
    input  logic [GW-1:0] gain_d,
    input  logic [IW-2:0] int_limit,
    output pid_out_t      res
);
    localparam int EW = TW + 1;
    localparam int AW = IW + 2*GW + 4;
    localparam longint M_MAXI = (longint'(1) << (CTRL_W-1)) - 1;
    localparam logic signed [AW-1:0] M_HI = AW'(M_MAXI);
    localparam logic signed [AW-1:0] M_LO = -M_HI - 1;

    logic signed [EW-1:0] err, err_q;
    logic signed [IW-1:0] integ_q, integ_nx;
    logic signed [AW-1:0] lim, sum_i, de, p_i, p_d, acc, prod;
    logic signed [CTRL_W-1:0] m_nx;
    logic                 force_open;
    duty_t                level_nx;

    always_comb begin
        err   = $signed({1'b0, temp_meas}) - $signed({1'b0, temp_set});
        lim   = AW'($signed({1'b0, int_limit}));
        sum_i = AW'(integ_q) + AW'(err);
        if (sum_i > lim)
            integ_nx = IW'(lim);
        else if (sum_i < -lim)
            integ_nx = IW'(-lim);
        else
            integ_nx = IW'(sum_i);
        de    = AW'(err) - AW'(err_q);
        p_i   = (AW'(integ_nx) * $signed(AW'({1'b0, gain_i}))) >>> GF;
        p_d   = (de * $signed(AW'({1'b0, gain_d}))) >>> GF;
        acc   = AW'(err) + p_i + p_d;
        prod  = (acc * $signed(AW'({1'b0, gain_p}))) >>> GF;
        if (prod > M_HI)
            m_nx = CTRL_W'(M_HI);
        else if (prod < M_LO)
            m_nx = CTRL_W'(M_LO);
        else
            m_nx = CTRL_W'(prod);
        force_open = (err <= 0) && (integ_nx <= 0);
        level_nx   = duty_quant(m_nx, STEP_SH, force_open);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= '0;
            integ_q <= '0;
            res     <= '0;
        end else if (stb) begin
            err_q     <= err;
            integ_q   <= integ_nx;
            res.m     <= m_nx;
            res.level <= level_nx;
        end
    end

    // R2: nothing moves between strobes
    p_hold_between_strobes_r2: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(res) && $stable(integ_q)));

    // R5: integrator stays within the clamp in force when it was written
    p_integ_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        stb |=> ((AW'(integ_q) <= $past(lim)) && (AW'(integ_q) >= -$past(lim))));

endmodule

// File: rtl/fpg_pattern.sv
module fpg_pattern
    import fpg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  duty_t level_in,
    output logic  fetch_en
);
    duty_t      cur;
    logic [2:0] slot;
    logic       last;

    always_comb begin
        last     = (slot == duty_period(cur) - 3'd1);
        fetch_en = (slot < duty_open_slots(cur));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= DUTY_FULL;
            slot <= '0;
        end else if (last) begin
            cur  <= level_in;
            slot <= '0;
        end else begin
            slot <= slot + 3'd1;
        end
    end

    // R9: setting is swapped only after a pattern's final slot
    p_swap_on_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur) |-> ($past(last) && slot == 3'd0));

    // R8: slot index never leaves the pattern
    p_slot_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        slot < duty_period(cur));

    // R8: one-in-five never opens two cycles in a row
    p_fifth_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (cur == DUTY_1_5 && fetch_en) |=> !fetch_en);

endmodule

// File: rtl/fetch_pid_gate.sv
module fetch_pid_gate
    import fpg_pkg::*;
#(
    parameter int TW      = 12,
    parameter int GW      = 8,
    parameter int GF      = 4,
    parameter int IW      = 16,
    parameter int STEP_SH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TW-1:0]     temp_meas,
    input  logic [TW-1:0]     temp_set,
    input  logic              sample_stb,
    input  logic [GW-1:0]     gain_p,
    input  logic [GW-1:0]     gain_i,
    input  logic [GW-1:0]     gain_d,
    input  logic [IW-2:0]     int_limit,
    output logic              fetch_en,
    output logic [2:0]        duty_level,
    output logic [CTRL_W-1:0] ctrl_out
);
    pid_out_t pid_res;

    fpg_pid #(
        .TW(TW), .GW(GW), .GF(GF), .IW(IW), .STEP_SH(STEP_SH)
    ) u_pid (
        .clk       (clk),
        .rst       (rst),
        .stb       (sample_stb),
        .temp_meas (temp_meas),
        .temp_set  (temp_set),
        .gain_p    (gain_p),
        .gain_i    (gain_i),
        .gain_d    (gain_d),
        .int_limit (int_limit),
        .res       (pid_res)
    );

    fpg_pattern u_pat (
        .clk      (clk),
        .rst      (rst),
        .level_in (pid_res.level),
        .fetch_en (fetch_en)
    );

    assign duty_level = pid_res.level;
    assign ctrl_out   = pid_res.m;

    // R6: a non-positive control value never throttles
    p_nonpos_open_r6: assert property (@(posedge clk) disable iff (rst)
        ($signed(ctrl_out) <= 0) |-> (duty_level == 3'd0));

    // R6: codes above 5 never appear
    p_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
        duty_level <= 3'd5);

endmodule

// File: tb/fetch_pid_gate_test.sv
module fetch_pid_gate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] temp_meas = '0;
    logic [11:0] temp_set  = 12'd100;
    logic        sample_stb = 1'b0;
    logic [7:0]  gain_p = 8'd16, gain_i = 8'd0, gain_d = 8'd0;
    logic [14:0] int_limit = 15'd1000;
    logic        fetch_en;
    logic [2:0]  duty_level;
    logic [15:0] ctrl_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fetch_pid_gate uut (
        .clk(clk), .rst(rst), .temp_meas(temp_meas), .temp_set(temp_set),
        .sample_stb(sample_stb), .gain_p(gain_p), .gain_i(gain_i), .gain_d(gain_d),
        .int_limit(int_limit), .fetch_en(fetch_en), .duty_level(duty_level),
        .ctrl_out(ctrl_out)
    );

    // table: temperature (target 100, Kp=1.0), expected code, ctrl, opens per 30 cycles
    localparam int NV = 8;
    localparam int V_TEMP [NV] = '{100, 101, 115, 116, 132, 150, 200, 90};
    localparam int V_LVL  [NV] = '{0,   1,   1,   2,   3,   4,   5,   0};
    localparam int V_M    [NV] = '{0,   1,   15,  16,  32,  50,  100, -10};
    localparam int V_CNT  [NV] = '{30,  24,  24,  20,  15,  10,  6,   30};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // strobe one sample, return after its result is visible
    task automatic pulse(input int t);
        temp_meas  = 12'(t);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic rec(output logic [9:0] v);
        for (int i = 0; i < 10; i++) begin
            v[9-i] = fetch_en;
            if (i < 9) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [9:0] seq;
        int cnt;

        // R1: reset state
        do_reset();
        check("R1 fetch_en", int'(fetch_en), 1);
        check("R1 duty_level", int'(duty_level), 0);
        check("R1 ctrl_out", int'($signed(ctrl_out)), 0);

        // R9: restart at boundary from a known phase
        pulse(200);
        check("R6 level 1/5", int'(duty_level), 5);
        rec(seq);
        check("R9 start of 1/5 pattern", int'(seq), int'(10'b1000010000));
        // strobe lands on the last slot of the 1/5 pattern
        temp_meas  = 12'd101;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        rec(seq);
        check("R9 strobe on last slot", int'(seq), int'(10'b1000011110));
        check("R3 ctrl unit gain", int'($signed(ctrl_out)), 1);

        // R2: no strobe, no change
        temp_meas = 12'd150;
        repeat (4) @(negedge clk);
        check("R2 ctrl held", int'($signed(ctrl_out)), 1);
        check("R2 level held", int'(duty_level), 1);

        // R6/R8 table walk
        for (int k = 0; k < NV; k++) begin
            pulse(V_TEMP[k]);
            repeat (6) @(negedge clk);
            check("R3 ctrl table", int'($signed(ctrl_out)), V_M[k]);
            check("R6 level table", int'(duty_level), V_LVL[k]);
            cnt = 0;
            for (int c = 0; c < 30; c++) begin
                cnt += int'(fetch_en);
                @(negedge clk);
            end
            check("R8 opens per 30", cnt, V_CNT[k]);
        end

        // R4: saturation both ways
        gain_p = 8'd255;
        temp_set = 12'd0;
        pulse(4095);
        check("R4 positive clamp", int'($signed(ctrl_out)), 32767);
        check("R6 level at clamp", int'(duty_level), 5);
        temp_set = 12'd4095;
        pulse(0);
        check("R4 negative clamp", int'($signed(ctrl_out)), -32768);
        check("R6 level negative", int'(duty_level), 0);

        // R7: derivative kick with negative error stays open
        do_reset();
        gain_p = 8'd16; gain_i = 8'd0; gain_d = 8'd16;
        temp_set = 12'd100;
        pulse(80);
        check("R3 ctrl with step", int'($signed(ctrl_out)), -40);
        pulse(98);
        check("R7 forced ctrl", int'($signed(ctrl_out)), 16);
        check("R7 forced open", int'(duty_level), 0);
        pulse(102);
        check("R3 ctrl small rise", int'($signed(ctrl_out)), 6);
        check("R7 released", int'(duty_level), 1);

        // R5: integrator clamp
        do_reset();
        gain_p = 8'd16; gain_i = 8'd16; gain_d = 8'd0;
        int_limit = 15'd20;
        pulse(110);
        check("R5 first sum", int'($signed(ctrl_out)), 20);
        pulse(110);
        check("R5 reach limit", int'($signed(ctrl_out)), 30);
        pulse(110);
        check("R5 held at limit", int'($signed(ctrl_out)), 30);
        pulse(90);
        check("R5 no windup", int'($signed(ctrl_out)), 0);
        check("R6 zero open", int'(duty_level), 0);
        pulse(60);
        check("R5 negative clamp", int'($signed(ctrl_out)), -60);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule